// File: doc/BRIEF.md
# Charger Input Source Selection Controller

This block decides which of three power paths feeds the system rail of a single-cell charger: the wall-adapter path, the USB path or the battery path. It also decides which input current limit applies. A source-select pin tells it whether the shared input connector carries an adapter or a USB port. A current-select pin then picks either the charge rate (adapter) or the input current limit (USB). A chip-enable input places the block in standby. Two comparator flags report whether input power is present at all and whether the input has fallen close to the battery voltage. A free-running millisecond tick paces the two timers.

When input first arrives in USB mode, the block runs a timed start-up window. For the whole window it applies the 100 mA USB limit and disregards chip-enable and current-select. Every hand-over between the two input paths is break-before-make: the outgoing switch opens, the battery carries the rail for a programmable dead time, and only then does the incoming switch close. Power-good is an active-low flag. It is released only once a sleep condition has persisted through a deglitch interval, but the rail moves to the battery at once.

Top module: `srcsel_ctrl`

## Requirements
- R1: With input usable, enable high and source-select high, the adapter switch alone is on one cycle later. The limit code is 3 (adapter), and half_rate equals the inverse of rate_sel (rate_sel low halves the charge rate).
- R2: With input usable, enable high, source-select low and no start-up window running, the USB switch alone is on. The limit code is 2 (500 mA) when rate_sel is high and 1 (100 mA) when it is low, and half_rate is 0.
- R3: One cycle after in_present is low, only the battery switch is on and the limit code is 0 (no input draw). Reset gives the same state, with pgood_n high.
- R4: A rising edge of in_present while source-select is low opens a start-up window of BOOT_MS ticks. During the window the USB switch is on with limit code 1, whatever chg_en and rate_sel are. After the window, those inputs take effect.
- R5: A rising edge of in_present while source-select is high opens no window. A window is never re-armed while in_present stays high.
- R6: With input usable and chg_en low (after any start-up window), both input switches are off, the battery switch is on and the limit code is 0.
- R7: One cycle after in_low_cmp goes high, both input switches are off and the battery switch is on, with no deglitch delay.
- R8: pgood_n is low one cycle after in_present is high while no sleep is declared. It rises only after in_low_cmp has stayed high for SLEEP_DGL ticks, it returns low two cycles after in_low_cmp falls, and it is high whenever in_present is low.
- R9: A change between the adapter and USB paths passes through DEAD_CYC cycles with both input switches off and the battery switch on. The two input switches are never on together, and neither is on in the cycle after the other was on.
- R10: bat_sw_en is high exactly when neither input switch is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| src_sel_ac | input | 1 | 1: input is an adapter, 0: input is a USB port |
| chg_en | input | 1 | Enable; low selects standby |
| rate_sel | input | 1 | Adapter: 1 full / 0 half rate; USB: 1 500 mA / 0 100 mA |
| in_present | input | 1 | Input supply detected |
| in_low_cmp | input | 1 | Input has dropped near battery voltage |
| ac_sw_en | output | 1 | Adapter path switch on |
| usb_sw_en | output | 1 | USB path switch on |
| bat_sw_en | output | 1 | Battery path switch on |
| ilim_code | output | 2 | 0 none, 1 100 mA, 2 500 mA, 3 adapter |
| half_rate | output | 1 | Half charge rate in adapter mode |
| pgood_n | output | 1 | Active-low power good |

## Verification
The bench first checks that the start-up window masks a low enable and a high current-select. A design that misses this would start in standby or at 500 mA. It then checks that an input arrival with source-select high gives the adapter path at once, so a window armed on the wrong edge would hold the rail at 100 mA. Adapter-to-USB and USB-to-adapter swaps are sampled cycle by cycle to catch a missing or short dead gap. A short sleep pulse is applied to confirm that the battery takes the rail at once while power-good stays asserted until the deglitch completes. Random mixes of source-select, enable, rate and brief sleep pulses are compared against a bench function. Throughout, a monitor watches every cycle for overlapping or back-to-back input switches.

// File: rtl/srcsel_pkg.sv
package srcsel_pkg;

    typedef enum logic [1:0] {
        SRC_BAT = 2'd0,
        SRC_AC  = 2'd1,
        SRC_USB = 2'd2,
        SRC_GAP = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        LIM_OFF = 2'd0,
        LIM_100 = 2'd1,
        LIM_500 = 2'd2,
        LIM_ADP = 2'd3
    } ilim_e;

    function automatic logic is_input_path(src_e s);
        return (s == SRC_AC) || (s == SRC_USB);
    endfunction

endpackage

// File: rtl/srcsel_boot_timer.sv
module srcsel_boot_timer #(
    parameter int BOOT_MS = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic in_present,
    input  logic src_sel_ac,
    output logic boot_act
);
    localparam int BW = $clog2(BOOT_MS + 1);

    typedef struct packed {
        logic          prev;
        logic [BW-1:0] cnt;
    } boot_s;

    boot_s bt_d, bt_q;
    logic  rise;

    always_comb begin
        bt_d      = bt_q;
        rise      = in_present && !bt_q.prev;
        bt_d.prev = in_present;
        if (!in_present || src_sel_ac) begin
            bt_d.cnt = '0;
        end else if (rise) begin
            bt_d.cnt = BW'(BOOT_MS);
        end else if (ms_tick && (bt_q.cnt != '0)) begin
            bt_d.cnt = bt_q.cnt - 1'b1;
        end
        boot_act = in_present && !src_sel_ac && (rise || (bt_q.cnt != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bt_q <= '0;
        else        bt_q <= bt_d;
    end

    // R5: with input held and the window closed, no new window opens
    a_r5_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (bt_q.prev && in_present && (bt_q.cnt == '0)) |=> (bt_q.cnt == '0))
        else $error("boot window re-armed");

    // R4: window never runs once input is gone
    a_r4_window_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !in_present |=> (bt_q.cnt == '0))
        else $error("boot window survived input loss");

endmodule

// File: rtl/srcsel_sleep_filter.sv
module srcsel_sleep_filter #(
    parameter int SLEEP_DGL = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic in_low_cmp,
    output logic sleep_decl
);
    localparam int SW = $clog2(SLEEP_DGL + 1);

    typedef struct packed {
        logic          decl;
        logic [SW-1:0] cnt;
    } slp_s;

    slp_s sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (!in_low_cmp) begin
            sl_d.cnt  = '0;
            sl_d.decl = 1'b0;
        end else if (ms_tick && !sl_q.decl) begin
            if (sl_q.cnt == SW'(SLEEP_DGL - 1)) sl_d.decl = 1'b1;
            else                                sl_d.cnt  = sl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign sleep_decl = sl_q.decl;

    // R8: a declared sleep always follows an asserted comparator
    a_r8_decl_follows_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        sl_q.decl |-> $past(in_low_cmp))
        else $error("sleep declared without comparator");

endmodule

// File: rtl/srcsel_path_seq.sv
module srcsel_path_seq
    import srcsel_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  src_e  tgt_src,
    input  ilim_e tgt_lim,
    input  logic  tgt_half,
    output src_e  cur_src,
    output ilim_e cur_lim,
    output logic  cur_half
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        src_e          src;
        logic [DW-1:0] gap;
        ilim_e         lim;
        logic          half;
    } seq_s;

    seq_s sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (sq_q.src == SRC_GAP) begin
            if (tgt_src == SRC_BAT)   sq_d.src = SRC_BAT;
            else if (sq_q.gap == '0)  sq_d.src = tgt_src;
            else                      sq_d.gap = sq_q.gap - 1'b1;
        end else if (tgt_src != sq_q.src) begin
            if (is_input_path(sq_q.src) && is_input_path(tgt_src)) begin
                sq_d.src = SRC_GAP;
                sq_d.gap = DW'(DEAD_CYC - 1);
            end else begin
                sq_d.src = tgt_src;
            end
        end
        if (sq_d.src == tgt_src) begin
            sq_d.lim  = tgt_lim;
            sq_d.half = tgt_half;
        end else begin
            sq_d.lim  = LIM_OFF;
            sq_d.half = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{src: SRC_BAT, gap: '0, lim: LIM_OFF, half: 1'b0};
        else        sq_q <= sq_d;
    end

    assign cur_src  = sq_q.src;
    assign cur_lim  = sq_q.lim;
    assign cur_half = sq_q.half;

    // R9: adapter path never hands straight to USB path and vice versa
    a_r9_ac_not_to_usb: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.src == SRC_AC) |=> (sq_q.src != SRC_USB))
        else $error("adapter to USB without gap");
    a_r9_usb_not_to_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.src == SRC_USB) |=> (sq_q.src != SRC_AC))
        else $error("USB to adapter without gap");

endmodule

// File: rtl/srcsel_ctrl.sv
module srcsel_ctrl
    import srcsel_pkg::*;
#(
    parameter int BOOT_MS   = 150,
    parameter int SLEEP_DGL = 23,
    parameter int DEAD_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       src_sel_ac,
    input  logic       chg_en,
    input  logic       rate_sel,
    input  logic       in_present,
    input  logic       in_low_cmp,
    output logic       ac_sw_en,
    output logic       usb_sw_en,
    output logic       bat_sw_en,
    output logic [1:0] ilim_code,
    output logic       half_rate,
    output logic       pgood_n
);
    typedef struct packed {
        logic pg_n;
    } top_s;

    top_s  tp_d, tp_q;
    logic  boot_act, sleep_decl, usable;
    src_e  tgt_src, cur_src;
    ilim_e tgt_lim, cur_lim;
    logic  tgt_half, cur_half;

    srcsel_boot_timer #(.BOOT_MS(BOOT_MS)) u_boot (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .in_present(in_present), .src_sel_ac(src_sel_ac), .boot_act(boot_act)
    );

    srcsel_sleep_filter #(.SLEEP_DGL(SLEEP_DGL)) u_sleep (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .in_low_cmp(in_low_cmp), .sleep_decl(sleep_decl)
    );

    always_comb begin
        usable   = in_present && !in_low_cmp;
        tgt_src  = SRC_BAT;
        tgt_lim  = LIM_OFF;
        tgt_half = 1'b0;
        if (usable) begin
            if (boot_act) begin
                tgt_src = SRC_USB;
                tgt_lim = LIM_100;
            end else if (chg_en) begin
                if (src_sel_ac) begin
                    tgt_src  = SRC_AC;
                    tgt_lim  = LIM_ADP;
                    tgt_half = !rate_sel;
                end else begin
                    tgt_src = SRC_USB;
                    tgt_lim = rate_sel ? LIM_500 : LIM_100;
                end
            end
        end
        tp_d      = tp_q;
        tp_d.pg_n = !(in_present && !sleep_decl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '{pg_n: 1'b1};
        else        tp_q <= tp_d;
    end

    srcsel_path_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .tgt_src(tgt_src), .tgt_lim(tgt_lim), .tgt_half(tgt_half),
        .cur_src(cur_src), .cur_lim(cur_lim), .cur_half(cur_half)
    );

    assign ac_sw_en  = (cur_src == SRC_AC);
    assign usb_sw_en = (cur_src == SRC_USB);
    assign bat_sw_en = (cur_src == SRC_BAT) || (cur_src == SRC_GAP);
    assign ilim_code = cur_lim;
    assign half_rate = cur_half;
    assign pgood_n   = tp_q.pg_n;

    // R3: absent input hands the rail to the battery next cycle
    a_r3_battery_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
        !in_present |=> (bat_sw_en && !ac_sw_en && !usb_sw_en))
        else $error("input path on without input");

    // R7: comparator drop moves the rail at once
    a_r7_immediate_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        in_low_cmp |=> (!ac_sw_en && !usb_sw_en))
        else $error("input path on during low input");

    // R4: USB path opened during the window carries the 100 mA limit
    a_r4_boot_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(boot_act) && usb_sw_en) |-> (ilim_code == LIM_100))
        else $error("boot window limit wrong");

    // R8: declared sleep releases power-good
    a_r8_pg_released: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_decl |=> pgood_n)
        else $error("power-good held in sleep");

endmodule

// File: tb/sim_srcsel_ctrl.sv
module sim_srcsel_ctrl;
    localparam int BOOT_MS   = 150;
    localparam int SLEEP_DGL = 23;
    localparam int DEAD_CYC  = 2;
    localparam int TDIV      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic src_sel_ac = 1'b0, chg_en = 1'b0, rate_sel = 1'b0;
    logic in_present = 1'b0, in_low_cmp = 1'b0;
    logic ac_sw_en, usb_sw_en, bat_sw_en, half_rate, pgood_n;
    logic [1:0] ilim_code;

    int n_chk = 0;
    int n_bad = 0;
    int ovl_bad = 0;
    int tick_cnt = 0;
    logic prev_ac = 1'b0, prev_usb = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    srcsel_ctrl #(.BOOT_MS(BOOT_MS), .SLEEP_DGL(SLEEP_DGL), .DEAD_CYC(DEAD_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .src_sel_ac(src_sel_ac),
        .chg_en(chg_en), .rate_sel(rate_sel), .in_present(in_present),
        .in_low_cmp(in_low_cmp), .ac_sw_en(ac_sw_en), .usb_sw_en(usb_sw_en),
        .bat_sw_en(bat_sw_en), .ilim_code(ilim_code), .half_rate(half_rate),
        .pgood_n(pgood_n)
    );

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == TDIV - 1) ? 0 : tick_cnt + 1;
        ms_tick  <= (tick_cnt == TDIV - 1);
        if (rst_n) begin
            if ((ac_sw_en && usb_sw_en) || (prev_ac && usb_sw_en) || (prev_usb && ac_sw_en))
                ovl_bad <= ovl_bad + 1;
            if (bat_sw_en == (ac_sw_en || usb_sw_en)) ovl_bad <= ovl_bad + 1;
        end
        prev_ac  <= ac_sw_en;
        prev_usb <= usb_sw_en;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // packs {ac, usb, bat, ilim[1:0], half}
    function automatic logic [5:0] outs();
        return {ac_sw_en, usb_sw_en, bat_sw_en, ilim_code, half_rate};
    endfunction

    function automatic logic [5:0] expect_steady(logic sel, logic en, logic rate, logic low);
        if (low || !en) return 6'b001_00_0;
        if (sel)        return {3'b100, 2'd3, !rate};
        return {3'b010, rate ? 2'd2 : 2'd1, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
        end
    end

    initial begin
        int r;
        r = $urandom(32'd4242);
        step(3);
        // R3 R10 reset state
        chk("R3 reset outputs", outs(), 6'b001_00_0);
        chk("R8 reset pgood", {5'd0, pgood_n}, 6'd1);
        rst_n = 1'b1;
        step(2);

        // R4 boot window with en low and rate high ignored
        src_sel_ac = 1'b0; chg_en = 1'b0; rate_sel = 1'b1; in_present = 1'b1;
        step(1);
        chk("R4 boot start usb 100mA", outs(), 6'b010_01_0);
        chk("R8 pgood with input", {5'd0, pgood_n}, 6'd0);
        step(TDIV * (BOOT_MS - 3));
        chk("R4 boot still active", outs(), 6'b010_01_0);
        step(TDIV * 5);
        chk("R6 standby after boot", outs(), 6'b001_00_0);
        chg_en = 1'b1;
        step(2);
        chk("R2 usb 500mA", outs(), 6'b010_10_0);
        rate_sel = 1'b0;
        step(1);
        chk("R2 usb 100mA", outs(), 6'b010_01_0);

        // R5 arrival with select high opens no window
        in_present = 1'b0;
        step(1);
        chk("R3 input removed", outs(), 6'b001_00_0);
        step(1);
        chk("R8 pgood released without input", {5'd0, pgood_n}, 6'd1);
        src_sel_ac = 1'b1; rate_sel = 1'b1; in_present = 1'b1;
        step(1);
        chk("R5 adapter at once", outs(), 6'b100_11_0);
        rate_sel = 1'b0;
        step(1);
        chk("R1 half rate", outs(), 6'b100_11_1);
        rate_sel = 1'b1;
        step(1);
        chk("R1 full rate", outs(), 6'b100_11_0);

        // R9 adapter to USB with dead gap, no window re-armed (R5)
        src_sel_ac = 1'b0;
        step(1);
        chk("R9 gap cycle 1", outs(), 6'b001_00_0);
        step(DEAD_CYC - 1);
        chk("R9 gap last cycle", outs(), 6'b001_00_0);
        step(1);
        chk("R9 usb after gap at 500mA (R5)", outs(), 6'b010_10_0);
        src_sel_ac = 1'b1;
        step(1);
        chk("R9 gap back to adapter", outs(), 6'b001_00_0);
        step(DEAD_CYC);
        chk("R9 adapter after gap", outs(), 6'b100_11_0);

        // R7 R8 sleep
        in_low_cmp = 1'b1;
        step(1);
        chk("R7 immediate battery", outs(), 6'b001_00_0);
        step(TDIV * (SLEEP_DGL - 3));
        chk("R8 pgood held during deglitch", {5'd0, pgood_n}, 6'd0);
        step(TDIV * 5);
        chk("R8 pgood released after deglitch", {5'd0, pgood_n}, 6'd1);
        in_low_cmp = 1'b0;
        step(1);
        chk("R7 adapter restored", outs(), 6'b100_11_0);
        step(1);
        chk("R8 pgood back low", {5'd0, pgood_n}, 6'd0);

        // random mix with input held present
        for (int i = 0; i < 60; i++) begin
            logic s, e, t, l;
            s = 1'($urandom % 2);
            e = 1'(($urandom % 4) != 0);
            t = 1'($urandom % 2);
            l = 1'(($urandom % 6) == 0);
            src_sel_ac = s; chg_en = e; rate_sel = t; in_low_cmp = l;
            step(DEAD_CYC + 4);
            chk("R1 R2 R6 R7 random", outs(), expect_steady(s, e, t, l));
            chk("R8 random pgood", {5'd0, pgood_n}, 6'd0);
            in_low_cmp = 1'b0;
            step(1);
        end

        chk("R9 R10 switch monitor", 6'(ovl_bad), 6'd0);
        done = 1'b1;
        summary();
    end
endmodule